// File: doc/BRIEF.md
# Level-Sensitive Interrupt Clear Controller

This block keeps one pending flag for each of 23 interrupt sources. Channels 0 to 20 are general channels. Channel 21 is the non-maskable channel and channel 22 is the host channel. Every request input is active low. A per-channel mode input selects how each flag is set and cleared.

A level-sensitive channel latches pending while its request is low. Only software clears it, by writing ones to one of two write-only clear words on a small 16-bit write port. An edge-sensitive channel latches pending on a falling edge of its request. Only a per-channel acknowledge input clears it, and clear words have no effect on it.

Priority, masking and vectoring belong to neighbouring logic, which reads the pending vector.

Top module: `lic_top`

## Requirements
- R1: While `rst_n` is low, every bit of `pend` is 0.
- R2: When a level channel (`level_mode[i]`=1) has `req_n[i]` low at a rising clock edge, `pend[i]` is 1 after that edge. It stays 1 after the request returns high, until a clear is applied.
- R3: A write with `wr_en`=1 and `wr_addr`=2 clears `pend[i]` for each data bit i in 15..0 that is 1, when channel i is a level channel.
- R4: A write with `wr_addr`=3 uses three data fields. Data bits 4..0 clear level channels 20..16. Data bit 6 clears the non-maskable channel (index 21). Data bit 7 clears the host channel (index 22).
- R5: A clear word written to an edge channel (`level_mode[i]`=0) leaves `pend[i]` unchanged.
- R6: The following leave `pend` unchanged: data bits written as 0; data bits 15..8 and bit 5 at offset 3; any write at offsets 0 and 1; any cycle with `wr_en`=0.
- R7: When a clear and a low request meet in the same cycle on a level channel, the flag stays 1. It stays 1 for as long as the request is still low.
- R8: An edge channel sets `pend[i]` after the first rising edge at which `req_n[i]` is seen low following a high sample. Holding the request low does not set the flag again.
- R9: `ack[i]`=1 clears `pend[i]` on an edge channel, and a new falling edge in the same cycle wins over it. On a level channel `ack[i]` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 23 | Active-low requests: 0..20 general, 21 non-maskable, 22 host |
| level_mode | input | 23 | 1 = level-sensitive, 0 = edge-sensitive, per channel |
| ack | input | 23 | Acknowledge pulses for edge channels |
| wr_en | input | 1 | Write strobe for the clear words |
| wr_addr | input | 2 | Word offset of the write |
| wr_data | input | 16 | Clear bits, 1 = clear |
| pend | output | 23 | Pending flags |

## Verification
Every result of this block is due one rising edge after its stimulus. A request, acknowledge or clear word presented before edge k is visible on `pend` just after edge k. The falling-edge detector holds a one-cycle history, so an edge is judged against the sample from the edge before. The bench drives inputs on the falling clock edge and compares `pend` a quarter period after the next rising edge. It carries state from vector to vector, so held flags, repeated clears and clear-against-set collisions are each seen in the cycle they resolve.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int unsigned GEN_CH   = 21;
  localparam int unsigned DW       = 16;
  localparam int unsigned AW       = 2;
  localparam int unsigned CH_N     = GEN_CH + 2;
  localparam int unsigned NMI_CH   = GEN_CH;
  localparam int unsigned HOST_CH  = GEN_CH + 1;
  localparam int unsigned HI_GEN   = GEN_CH - DW;
  localparam int unsigned OFF_LO   = 2;
  localparam int unsigned OFF_HI   = 3;
  localparam int unsigned NMI_BIT  = 6;
  localparam int unsigned HOST_BIT = 7;

  typedef logic [CH_N-1:0] chvec_t;

  // Map one write onto a per-channel clear request vector.
  function automatic chvec_t clear_mask(input logic we, input logic [AW-1:0] addr,
                                        input logic [DW-1:0] d);
    chvec_t m;
    m = '0;
    if (we && addr == AW'(OFF_LO)) begin
      for (int i = 0; i < int'(DW); i++) m[i] = d[i];
    end else if (we && addr == AW'(OFF_HI)) begin
      for (int i = 0; i < int'(HI_GEN); i++) m[int'(DW) + i] = d[i];
      m[NMI_CH]  = d[NMI_BIT];
      m[HOST_CH] = d[HOST_BIT];
    end
    return m;
  endfunction

  // Next pending value: a set event wins over a clear event.
  function automatic logic next_pend(input logic cur, input logic set_ev, input logic clr_ev);
    return set_ev | (cur & ~clr_ev);
  endfunction
endpackage

// File: rtl/lic_clear_decode.sv
module lic_clear_decode
  import lic_pkg::*;
(
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output chvec_t        clr_req
);
  assign clr_req = clear_mask(wr_en, wr_addr, wr_data);
endmodule

// File: rtl/lic_edge_detect.sv
module lic_edge_detect
  import lic_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  chvec_t req_n,
  output chvec_t active,
  output chvec_t fall
);
  chvec_t prev_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_n <= '1;
    else        prev_n <= req_n;
  end

  assign active = ~req_n;
  assign fall   = prev_n & ~req_n;
endmodule

// File: rtl/lic_pend_cell.sv
module lic_pend_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic active,
  input  logic fall,
  input  logic clr,
  input  logic ack,
  output logic pend
);
  logic set_ev;
  logic clr_ev;

  assign set_ev = lvl ? active : fall;
  assign clr_ev = lvl ? clr : ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= lic_pkg::next_pend(pend, set_ev, clr_ev);
  end

  // R2 R7
  level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl && active) |=> pend);

  // R3
  level_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl && clr && !active) |=> !pend);

  // R5
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl && pend && !ack) |=> pend);

  // R8
  edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl && fall) |=> pend);

  // R9
  edge_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl && ack && !fall) |=> !pend);
endmodule

// File: rtl/lic_top.sv
module lic_top
  import lic_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CH_N-1:0]     req_n,
  input  logic [CH_N-1:0]     level_mode,
  input  logic [CH_N-1:0]     ack,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  output logic [CH_N-1:0]     pend
);
  chvec_t clr_req;
  chvec_t active;
  chvec_t fall;

  lic_clear_decode u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .clr_req (clr_req)
  );

  lic_edge_detect u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_n  (req_n),
    .active (active),
    .fall   (fall)
  );

  for (genvar c = 0; c < int'(CH_N); c++) begin : g_ch
    lic_pend_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (level_mode[c]),
      .active (active[c]),
      .fall   (fall[c]),
      .clr    (clr_req[c]),
      .ack    (ack[c]),
      .pend   (pend[c])
    );
  end

  // R6
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || (wr_addr != AW'(OFF_LO) && wr_addr != AW'(OFF_HI))) |-> (clr_req == '0));

  // R4
  hi_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(OFF_HI)) |-> (clr_req[DW-1:0] == '0));
endmodule

// File: tb/tb_lic_top.sv
module tb_lic_top;
  localparam int CLK_P = 10;
  localparam logic [22:0] ALL = 23'h7FFFFF;

  typedef struct packed {
    logic [22:0] lo;
    logic [22:0] lvl;
    logic [22:0] ack;
    logic        we;
    logic [1:0]  addr;
    logic [15:0] data;
    logic [22:0] expv;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t TBL [NV] = '{
    '{23'h0,      ALL,   23'h0, 1'b0, 2'd0, 16'h0000, 23'h000000, 4'd2}, // R2 idle
    '{23'h000001, ALL,   23'h0, 1'b0, 2'd0, 16'h0000, 23'h000001, 4'd2}, // R2 set ch0
    '{23'h0,      ALL,   23'h0, 1'b0, 2'd0, 16'h0000, 23'h000001, 4'd2}, // R2 held
    '{23'h0,      ALL,   23'h0, 1'b1, 2'd2, 16'h0001, 23'h000000, 4'd3}, // R3 clear ch0
    '{23'h610000, ALL,   23'h0, 1'b0, 2'd0, 16'h0000, 23'h610000, 4'd2}, // R2 ch16,nmi,host
    '{23'h0,      ALL,   23'h0, 1'b1, 2'd3, 16'h0040, 23'h410000, 4'd4}, // R4 nmi
    '{23'h0,      ALL,   23'h0, 1'b1, 2'd3, 16'h0081, 23'h000000, 4'd4}, // R4 host, ch16
    '{23'h108000, ALL,   23'h0, 1'b0, 2'd0, 16'h0000, 23'h108000, 4'd2}, // R2 ch15,ch20
    '{23'h0,      ALL,   23'h0, 1'b1, 2'd2, 16'h0000, 23'h108000, 4'd6}, // R6 zeros
    '{23'h0,      ALL,   23'h0, 1'b1, 2'd3, 16'hFF20, 23'h108000, 4'd6}, // R6 unused hi bits
    '{23'h0,      ALL,   23'h0, 1'b1, 2'd1, 16'hFFFF, 23'h108000, 4'd6}, // R6 offset 1
    '{23'h0,      ALL,   23'h0, 1'b0, 2'd2, 16'hFFFF, 23'h108000, 4'd6}, // R6 no strobe
    '{23'h0,      ALL,   23'h0, 1'b1, 2'd2, 16'h8000, 23'h100000, 4'd3}, // R3 ch15
    '{23'h0,      ALL,   23'h0, 1'b1, 2'd3, 16'h0010, 23'h000000, 4'd4}, // R4 ch20
    '{23'h000008, ALL,   23'h0, 1'b1, 2'd2, 16'h0008, 23'h000008, 4'd7}, // R7 set wins
    '{23'h000008, ALL,   23'h0, 1'b1, 2'd2, 16'h0008, 23'h000008, 4'd7}, // R7 still low
    '{23'h0,      ALL,   23'h0, 1'b1, 2'd2, 16'h0008, 23'h000000, 4'd3}, // R3 released
    '{23'h0,      23'h0, 23'h0, 1'b0, 2'd0, 16'h0000, 23'h000000, 4'd8}, // R8 idle edge
    '{23'h000004, 23'h0, 23'h0, 1'b0, 2'd0, 16'h0000, 23'h000004, 4'd8}, // R8 fall ch2
    '{23'h000004, 23'h0, 23'h0, 1'b1, 2'd2, 16'hFFFF, 23'h000004, 4'd5}, // R5 ignored
    '{23'h000004, 23'h0, 23'h4, 1'b0, 2'd0, 16'h0000, 23'h000000, 4'd9}, // R9 ack
    '{23'h000004, 23'h0, 23'h0, 1'b0, 2'd0, 16'h0000, 23'h000000, 4'd8}, // R8 no reset
    '{23'h0,      23'h0, 23'h0, 1'b0, 2'd0, 16'h0000, 23'h000000, 4'd8}, // R8 release
    '{23'h000004, 23'h0, 23'h4, 1'b0, 2'd0, 16'h0000, 23'h000004, 4'd9}, // R9 fall beats ack
    '{23'h0,      23'h0, 23'h0, 1'b1, 2'd3, 16'h00C0, 23'h000004, 4'd5}, // R5 hi ignored
    '{23'h0,      23'h0, 23'h4, 1'b0, 2'd0, 16'h0000, 23'h000000, 4'd9}, // R9 ack
    '{23'h000002, ALL,   23'h0, 1'b0, 2'd0, 16'h0000, 23'h000002, 4'd2}, // R2 ch1
    '{23'h0,      ALL,   23'h2, 1'b0, 2'd0, 16'h0000, 23'h000002, 4'd9}, // R9 ack on level
    '{23'h0,      ALL,   23'h0, 1'b1, 2'd2, 16'h0002, 23'h000000, 4'd3}  // R3 clear ch1
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [22:0] req_n = ALL;
  logic [22:0] level_mode = '0;
  logic [22:0] ack = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [22:0] pend;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  lic_top dut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .level_mode(level_mode), .ack(ack),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pend(pend)
  );

  task automatic check(input string tag, input logic [22:0] expv);
    n_chk++;
    if (pend !== expv) begin
      n_bad++;
      $display("FAIL %s pend=%06h expected=%06h", tag, pend, expv);
    end
  endtask

  initial begin
    #(CLK_P*3);
    check("R1", 23'h0); // R1 in reset
    @(negedge clk) rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      req_n = ~TBL[k].lo;
      level_mode = TBL[k].lvl;
      ack = TBL[k].ack;
      wr_en = TBL[k].we;
      wr_addr = TBL[k].addr;
      wr_data = TBL[k].data;
      @(posedge clk);
      #(CLK_P/4);
      check($sformatf("R%0d vec%0d", TBL[k].rq, k), TBL[k].expv);
    end
    // R1 directed: reset drops flags held by a low level request
    @(negedge clk);
    ack = '0; wr_en = 1'b0; level_mode = ALL; req_n = ~23'h600001;
    @(posedge clk); #(CLK_P/4);
    check("R2 pre-reset", 23'h600001);
    rst_n = 1'b0;
    #1;
    check("R1 async", 23'h0);
    @(negedge clk) req_n = ALL;
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #(CLK_P/4);
    check("R1 after release", 23'h0);
    // R4 directed: host clear leaves nmi pending
    @(negedge clk) req_n = ~23'h600000;
    @(negedge clk) begin req_n = ALL; wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'h0080; end
    @(posedge clk); #(CLK_P/4);
    check("R4 host only", 23'h200000);
    @(negedge clk) wr_en = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P*200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule